// File: doc/BRIEF.md
# ADC Result Byte Pair with Read Interlock

This block keeps the most recent converter result in two byte-wide registers that a processor bus reads one byte at a time. The converter side is modelled as a one-cycle completion strobe that comes with a result word. The bus side is a plain read port: a strobe and a select that picks the upper or the lower byte. The selected byte is always shown on the read data output without delay. The strobe only tells the block that the byte was consumed.

In 10-bit mode the result does not fit in one byte, so a read of the upper byte freezes the pair until the lower byte is read. Both bytes a program collects therefore come from the same conversion. Any conversion that completes while the pair is frozen is dropped. An optional sticky flag records that a result was dropped. In 8-bit mode the whole result sits in the lower byte, the upper byte reads as zero, and no freezing takes place.

Top module: `adc_result_latch`

## Requirements
- R1: After synchronous reset both bytes read 0x00 and the overrun flag is 0. Only reset clears the flag.
- R2: In 10-bit mode (mode_10b = 1), a conversion accepted on a clock edge makes the upper byte read {6'b0, data[9:8]} and the lower byte read data[7:0] from the next cycle on. The upper byte's bits 7:2 always read 0.
- R3: In 8-bit mode (mode_10b = 0) the upper byte reads 0x00 and the lower byte reads data[7:0] of the last accepted conversion.
- R4: In 10-bit mode a read of the upper byte (rd_en = 1, rd_sel_hi = 1) locks the pair. A conversion completing in that cycle or in any later cycle before the unlocking lower-byte read is discarded, and both bytes keep their values.
- R5: A read of the lower byte (rd_en = 1, rd_sel_hi = 0) releases the lock. A conversion completing in the same cycle as that read is accepted.
- R6: A lower-byte read when no lock is pending changes nothing. Following conversions are accepted as usual.
- R7: In 8-bit mode reads of either byte never lock, and every completed conversion is accepted.
- R8: A change of mode_10b releases a pending lock. A conversion completing in the cycle of the change is accepted, unless that cycle also holds an upper-byte read in 10-bit mode.
- R9: Each discarded conversion sets the overrun flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe: a conversion has completed |
| conv_data | input | 10 | Result word that comes with conv_done |
| mode_10b | input | 1 | 1 = 10-bit results, 0 = 8-bit results |
| rd_en | input | 1 | Read strobe for the selected byte |
| rd_sel_hi | input | 1 | 1 = upper byte, 0 = lower byte |
| rd_data | output | 8 | Selected byte, shown combinationally |
| overrun | output | 1 | Sticky: a conversion was discarded |

## Verification
The hardest cases to reach are the ones where a conversion lands in the same cycle as a bus read. Landing with the upper-byte read must lose the result. Landing with the unlocking lower-byte read must keep it. Landing on a mode change must keep it. The stimulus uses a single-cycle step task that drives the strobe, the read and the mode together on one edge, so each of these coincidences is produced on purpose. A reference model in the bench predicts each byte returned, and a monitor compares every read against a queue of those predictions.

// File: rtl/adc_rl_pkg.sv
package adc_rl_pkg;

    localparam int RL_RES_W  = 10;
    localparam int RL_BYTE_W = 8;

    typedef struct packed {
        logic [RL_BYTE_W-1:0] hi;
        logic [RL_BYTE_W-1:0] lo;
    } rl_pair_t;

    typedef enum logic [1:0] {
        RL_IDLE    = 2'd0,
        RL_ACCEPT  = 2'd1,
        RL_DISCARD = 2'd2
    } rl_xfer_e;

    // Split a result word into the two bus bytes for the given mode.
    function automatic rl_pair_t rl_split(input logic [RL_RES_W-1:0] d,
                                          input logic wide);
        rl_pair_t p;
        p.lo = d[RL_BYTE_W-1:0];
        p.hi = '0;
        if (wide) begin
            p.hi[RL_RES_W-RL_BYTE_W-1:0] = d[RL_RES_W-1:RL_BYTE_W];
        end
        return p;
    endfunction

endpackage

// File: rtl/rl_lock_ctrl.sv
module rl_lock_ctrl
    import adc_rl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     conv_done,
    input  logic     mode_10b,
    input  logic     rd_en,
    input  logic     rd_sel_hi,
    output logic     lock_q,
    output logic     mode_chg,
    output rl_xfer_e xfer
);

    logic mode_q;
    logic hi_rd_wide;
    logic lo_rd;
    logic hold;

    assign hi_rd_wide = mode_10b & rd_en & rd_sel_hi;
    assign lo_rd      = rd_en & ~rd_sel_hi;
    assign mode_chg   = (mode_q != mode_10b);

    // A standing lock holds unless released this cycle; an upper read
    // in 10-bit mode holds its own cycle so the bytes cannot tear.
    assign hold = (lock_q & ~lo_rd & ~mode_chg) | hi_rd_wide;

    always_comb begin
        if (!conv_done) begin
            xfer = RL_IDLE;
        end else if (hold) begin
            xfer = RL_DISCARD;
        end else begin
            xfer = RL_ACCEPT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            mode_q <= mode_10b;
        end else begin
            mode_q <= mode_10b;
            if (hi_rd_wide) begin
                lock_q <= 1'b1;
            end else if (lo_rd || mode_chg) begin
                lock_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rl_result_regs.sv
module rl_result_regs
    import adc_rl_pkg::*;
#(
    parameter int RES_W       = RL_RES_W,
    parameter bit HAS_OVERRUN = 1'b1
)(
    input  logic             clk,
    input  logic             rst,
    input  rl_xfer_e         xfer,
    input  logic [RES_W-1:0] conv_data,
    input  logic             mode_10b,
    output rl_pair_t         pair_q,
    output logic             overrun
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
        end else if (xfer == RL_ACCEPT) begin
            pair_q <= rl_split(conv_data, mode_10b);
        end
    end

    generate
        if (HAS_OVERRUN) begin : g_ovr
            logic ovr_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    ovr_q <= 1'b0;
                end else if (xfer == RL_DISCARD) begin
                    ovr_q <= 1'b1;
                end
            end
            assign overrun = ovr_q;
        end else begin : g_no_ovr
            assign overrun = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/rl_read_mux.sv
module rl_read_mux
    import adc_rl_pkg::*;
#(
    parameter int BYTE_W = RL_BYTE_W
)(
    input  rl_pair_t          pair_q,
    input  logic              mode_10b,
    input  logic              rd_sel_hi,
    output logic [BYTE_W-1:0] rd_data
);

    always_comb begin
        if (rd_sel_hi) begin
            rd_data = mode_10b ? pair_q.hi : '0;
        end else begin
            rd_data = pair_q.lo;
        end
    end

endmodule

// File: rtl/adc_result_latch.sv
module adc_result_latch
    import adc_rl_pkg::*;
#(
    parameter int RES_W       = RL_RES_W,
    parameter int BYTE_W      = RL_BYTE_W,
    parameter bit HAS_OVERRUN = 1'b1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_data,
    input  logic              mode_10b,
    input  logic              rd_en,
    input  logic              rd_sel_hi,
    output logic [BYTE_W-1:0] rd_data,
    output logic              overrun
);

    logic     lock_active;
    logic     mode_chg;
    rl_xfer_e xfer;
    rl_pair_t pair_q;

    rl_lock_ctrl u_lock (
        .clk       (clk),
        .rst       (rst),
        .conv_done (conv_done),
        .mode_10b  (mode_10b),
        .rd_en     (rd_en),
        .rd_sel_hi (rd_sel_hi),
        .lock_q    (lock_active),
        .mode_chg  (mode_chg),
        .xfer      (xfer)
    );

    rl_result_regs #(
        .RES_W       (RES_W),
        .HAS_OVERRUN (HAS_OVERRUN)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .xfer      (xfer),
        .conv_data (conv_data),
        .mode_10b  (mode_10b),
        .pair_q    (pair_q),
        .overrun   (overrun)
    );

    rl_read_mux #(
        .BYTE_W (BYTE_W)
    ) u_mux (
        .pair_q    (pair_q),
        .mode_10b  (mode_10b),
        .rd_sel_hi (rd_sel_hi),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/rl_checker.sv
module rl_checker (
    input logic       clk,
    input logic       rst,
    input logic       conv_done,
    input logic       mode_10b,
    input logic       rd_en,
    input logic       rd_sel_hi,
    input logic [7:0] rd_data,
    input logic       overrun,
    input logic       lock_active,
    input logic       mode_chg
);

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R9

    AST_HI_ZERO_NARROW: assert property (@(posedge clk) disable iff (rst)
        (!mode_10b && rd_sel_hi) |-> (rd_data == 8'h00)); // R3

    AST_HI_UPPER_BITS: assert property (@(posedge clk) disable iff (rst)
        (mode_10b && rd_sel_hi) |-> (rd_data[7:2] == 6'b0)); // R2

    AST_HI_READ_LOCKS: assert property (@(posedge clk) disable iff (rst)
        (mode_10b && rd_en && rd_sel_hi) |=> lock_active); // R4

    AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (rst)
        (lock_active && conv_done && !(rd_en && !rd_sel_hi) && !mode_chg)
        |=> overrun); // R4

    AST_LO_READ_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_sel_hi) |=> !lock_active); // R5

    AST_NO_LOCK_NARROW: assert property (@(posedge clk) disable iff (rst)
        (!mode_10b && !mode_chg) |-> !lock_active); // R7

endmodule

bind adc_result_latch rl_checker u_rl_checker (
    .clk         (clk),
    .rst         (rst),
    .conv_done   (conv_done),
    .mode_10b    (mode_10b),
    .rd_en       (rd_en),
    .rd_sel_hi   (rd_sel_hi),
    .rd_data     (rd_data),
    .overrun     (overrun),
    .lock_active (lock_active),
    .mode_chg    (mode_chg)
);

// File: tb/test_adc_result_latch.sv
module test_adc_result_latch;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       conv_done = 1'b0;
    logic [9:0] conv_data = '0;
    logic       mode_10b = 1'b1;
    logic       rd_en = 1'b0;
    logic       rd_sel_hi = 1'b0;
    logic [7:0] rd_data;
    logic       overrun;

    int checks = 0;
    int failures = 0;

    // reference model state
    logic [7:0] m_hi, m_lo;
    logic       m_lock, m_ovr, m_mode;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_result_latch i_adc_result_latch (
        .clk       (clk),
        .rst       (rst),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .mode_10b  (mode_10b),
        .rd_en     (rd_en),
        .rd_sel_hi (rd_sel_hi),
        .rd_data   (rd_data),
        .overrun   (overrun)
    );

    // monitor: every strobed read is compared with the next prediction
    always @(negedge clk) begin
        if (!rst && rd_en) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data !== e) begin
                failures++;
                $display("FAIL %s read: got %02h expected %02h", t, rd_data, e);
            end
        end
    end

    task automatic do_reset(input bit m);
        rst = 1'b1; mode_10b = m;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        m_hi = 8'h00; m_lo = 8'h00; m_lock = 1'b0; m_ovr = 1'b0; m_mode = m;
    endtask

    // one cycle of stimulus; the model applies the requirements
    task automatic step(input string tag, input bit cd, input logic [9:0] d,
                        input bit rd, input bit hi, input bit m);
        bit hold, chg, lo_rd, hi_rd;
        conv_done = cd; conv_data = d; rd_en = rd; rd_sel_hi = hi; mode_10b = m;
        if (rd) begin
            exp_q.push_back(hi ? (m ? m_hi : 8'h00) : m_lo);
            tag_q.push_back(tag);
        end
        chg   = (m != m_mode);
        lo_rd = rd && !hi;
        hi_rd = m && rd && hi;
        hold  = (m_lock && !lo_rd && !chg) || hi_rd;
        @(posedge clk);
        #1;
        if (cd && !hold) begin
            m_lo = d[7:0];
            m_hi = m ? {6'b0, d[9:8]} : 8'h00;
        end
        if (cd && hold) m_ovr = 1'b1;
        if (hi_rd) m_lock = 1'b1;
        else if (lo_rd || chg) m_lock = 1'b0;
        m_mode = m;
        conv_done = 1'b0; rd_en = 1'b0;
    endtask

    task automatic chk_ovr(input string tag);
        checks++;
        if (overrun !== m_ovr) begin
            failures++;
            $display("FAIL %s overrun: got %0b expected %0b", tag, overrun, m_ovr);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset(1'b1);
        // R1 reset values
        step("R1", 0, 0, 1, 1, 1);
        step("R1", 0, 0, 1, 0, 1);
        chk_ovr("R1");

        // R2 10-bit split
        step("R2", 1, 10'h2A5, 0, 0, 1);
        step("R2", 0, 0, 0, 0, 1);
        step("R6", 0, 0, 1, 0, 1);          // R6 unlocked low read
        step("R6", 1, 10'h1C3, 0, 0, 1);    // accepted after it
        // R4 lock: upper read then a conversion inside the lock
        step("R4", 0, 0, 1, 1, 1);
        step("R4", 1, 10'h1FF, 0, 0, 1);
        step("R4", 0, 0, 1, 0, 1);
        chk_ovr("R9");
        step("R4", 0, 0, 1, 1, 1);
        step("R4", 0, 0, 1, 0, 1);

        // R4 conversion in the same cycle as the upper read is lost
        step("R4", 1, 10'h3C3, 1, 1, 1);
        // R5 conversion with the unlocking low read is kept
        step("R5", 1, 10'h0F0, 1, 0, 1);
        step("R5", 0, 0, 1, 1, 1);
        step("R5", 0, 0, 1, 0, 1);
        step("R5", 1, 10'h155, 0, 0, 1);
        step("R5", 0, 0, 1, 1, 1);
        step("R5", 0, 0, 1, 0, 1);

        // R8 mode change releases lock; same-cycle conversion accepted
        step("R8", 0, 0, 1, 1, 1);
        step("R8", 1, 10'h3AB, 0, 0, 0);
        step("R3", 0, 0, 1, 1, 0);
        step("R3", 0, 0, 1, 0, 0);
        // R7 narrow mode: upper read never locks
        step("R7", 1, 10'h0CD, 1, 1, 0);
        step("R7", 1, 10'h0EE, 0, 0, 0);
        step("R7", 0, 0, 1, 0, 0);
        step("R3", 0, 0, 1, 1, 0);
        // back to wide: no lock carried, result shown in new format
        step("R8", 1, 10'h2D2, 0, 0, 1);
        step("R2", 0, 0, 1, 1, 1);
        step("R2", 0, 0, 1, 0, 1);
        chk_ovr("R9");
        step("R9", 0, 0, 0, 0, 1);
        chk_ovr("R9");

        // R1 reset clears the sticky flag and data
        do_reset(1'b1);
        chk_ovr("R1");
        step("R1", 0, 0, 1, 1, 1);
        step("R1", 0, 0, 1, 0, 1);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule